// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is a synchronous master that fetches one 14-bit conversion result from a single-channel successive-approximation converter over a three-wire serial link: an active-low select, a serial clock and a data return line. A start request pulls the select line low, and that edge starts the conversion. The controller then waits half a serial-clock period and issues 24 clock pulses. The serial clock idles low. The converter changes its data on the falling clock edge, so the controller samples the data line on each rising edge. The 24-bit frame has three parts: eight leading bits that must be zero, the sample from its most significant bit down to its least, and two trailing sub-bits. The controller removes this framing. It returns the sample, the sub-bits and a framing-error flag on a result port. The flag is set when any leading bit is one.

The serial clock is derived from the system clock by a divider with a parameterised half period. After each frame the select line stays high for a guard time before the next frame may start. The guard time is a parameter in nanoseconds, converted into whole system-clock cycles and rounded up. An abort input ends a frame at once: select goes high, the partial result is discarded, and the guard time still applies.

The result port follows valid/ready rules. While `res_valid_o` is high and `res_ready_i` is low, the result fields are held unchanged. The transfer completes on a clock edge where both are high. No new frame is started while a result is waiting. This back-pressure therefore stalls conversions and never drops a result. `start_i` and `abort_i` are plain level controls that are sampled on each clock edge.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `spi_cs_n_o` is 1, `spi_sclk_o` is 0, `busy_o` is 0 and `res_valid_o` is 0.
- R2: When the controller is idle, no result is waiting and `start_i` is 1 at a clock edge, `spi_cs_n_o` goes to 0 at that edge and `busy_o` becomes 1.
- R3: `spi_sclk_o` is 0 whenever `spi_cs_n_o` is 1. The first rising edge comes DIV_HALF system cycles after select falls, and every later level change of the serial clock within a frame comes DIV_HALF cycles after the previous one.
- R4: A complete frame has exactly 24 rising serial-clock edges. `spi_cs_n_o` rises on the same system clock edge as the 24th falling serial-clock edge.
- R5: The data line is sampled on each rising edge. Frame bit positions 1–8 are leading bits. Positions 9–22 go to `res_sample_o[13]` down to `res_sample_o[0]`. Position 23 goes to `res_sub_o[1]` and position 24 goes to `res_sub_o[0]`.
- R6: `res_ferr_o` is 1 exactly when at least one of the eight leading bits was sampled as 1.
- R7: While `res_valid_o` is 1 and `res_ready_i` is 0, the valid flag and all result fields stay unchanged, and `start_i` does not lower `spi_cs_n_o`.
- R8: Between the end of one frame and the next falling edge of `spi_cs_n_o`, select stays high for at least GUARD_CYC system cycles, where GUARD_CYC = ceil(GUARD_NS*1000/CLK_PS).
- R9: `abort_i` = 1 during a frame drives `spi_cs_n_o` to 1 and `spi_sclk_o` to 0 at the next edge. No result is produced for that frame, and the guard time of R8 still applies.
- R10: `abort_i` while no frame is active has no effect. Select stays high, no result appears, and the next frame works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion frame (level) |
| abort_i | input | 1 | Abort the frame in progress |
| busy_o | output | 1 | A frame or guard interval is in progress |
| spi_cs_n_o | output | 1 | Active-low converter select |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_miso_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | Result is valid |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_sample_o | output | 14 | Conversion sample, MSB first in the frame |
| res_sub_o | output | 2 | Trailing sub-bits S1 (bit 1) and S0 (bit 0) |
| res_ferr_o | output | 1 | A leading framing bit was nonzero |

## Verification
A wrong bit counter shows at the select pin within one frame: select rises after too few or too many rising edges, and every later field is shifted, so the sample that comes back is wrong. A divider or state error shows within a single half period as a mistimed clock edge or a clock edge while select is high. A broken guard counter or a missed abort shows at the next falling edge of select, which comes too early or does not come at all. A broken back-pressure path shows as result fields that change, or a frame that starts, while the consumer is stalled.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int LEAD_BITS  = 8;
  localparam int DATA_BITS  = 14;
  localparam int SUB_BITS   = 2;
  localparam int FRAME_BITS = LEAD_BITS + DATA_BITS + SUB_BITS;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GUARD  = 2'd2
  } rd_state_e;

  typedef struct packed {
    logic                 ferr;
    logic [DATA_BITS-1:0] sample;
    logic [SUB_BITS-1:0]  sub;
  } adc_result_t;

endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int DIV_HALF = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CMAX = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  // The counter rests at zero while stopped, so no tick is possible then.
  assign tick    = (cnt_q == CMAX);
  assign rise_tk = tick && !sclk_q;
  assign fall_tk = tick && sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R3: a stopped divider leaves the serial clock low on the next cycle
  p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int NBITS = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       sample,
  input  logic                       bit_in,
  output logic [NBITS-1:0]           word,
  output logic [$clog2(NBITS+1)-1:0] nbits
);
  localparam int CW = $clog2(NBITS + 1);

  logic [NBITS-1:0] sh_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sample) begin
      sh_q  <= {sh_q[NBITS-2:0], bit_in};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word  = sh_q;
  assign nbits = cnt_q;

  // R4: never more than one frame of bits is captured
  p_bits_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NBITS));

  // R4: a full count is not extended by another sample
  p_no_extra_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(NBITS)) && !clr |=> cnt_q == CW'(NBITS));

endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int GW = $clog2(CYCLES + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= GW'(CYCLES - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R8: a load always starts a fresh wait
  p_load_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load && (CYCLES > 1) |=> !done);

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF = 21,
  parameter int CLK_PS   = 5000,
  parameter int GUARD_NS = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 abort_i,
  output logic                 busy_o,
  output logic                 spi_cs_n_o,
  output logic                 spi_sclk_o,
  input  logic                 spi_miso_i,
  output logic                 res_valid_o,
  input  logic                 res_ready_i,
  output logic [DATA_BITS-1:0] res_sample_o,
  output logic [SUB_BITS-1:0]  res_sub_o,
  output logic                 res_ferr_o
);
  localparam int GUARD_CYC = (GUARD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int GUARD_EFF = (GUARD_CYC < 1) ? 1 : GUARD_CYC;
  localparam int CW        = $clog2(FRAME_BITS + 1);
  localparam int HW        = $clog2(GUARD_EFF + 2);

  rd_state_e st_q, st_d;
  logic      cs_n_q;
  logic      run, rise_tk, fall_tk, sclk;
  logic      accept, finish, kill;
  logic      guard_done;
  logic [FRAME_BITS-1:0] word;
  logic [CW-1:0]         nbits;
  adc_result_t           res_q;
  logic                  res_v_q;

  assign accept = (st_q == ST_IDLE) && start_i && !res_v_q;
  assign kill   = (st_q == ST_ACTIVE) && abort_i;
  assign finish = (st_q == ST_ACTIVE) && !abort_i && fall_tk &&
                  (nbits == CW'(FRAME_BITS));
  assign run    = (st_q == ST_ACTIVE) && !abort_i && !finish;

  sclk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sclk    (sclk),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  frame_shifter #(.NBITS(FRAME_BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .sample ((st_q == ST_ACTIVE) && rise_tk && !abort_i),
    .bit_in (spi_miso_i),
    .word   (word),
    .nbits  (nbits)
  );

  guard_timer #(.CYCLES(GUARD_EFF)) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (kill || finish),
    .done  (guard_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept)         st_d = ST_ACTIVE;
      ST_ACTIVE: if (kill || finish) st_d = ST_GUARD;
      ST_GUARD:  if (guard_done)     st_d = ST_IDLE;
      default:                       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (accept)              cs_n_q <= 1'b0;
      else if (kill || finish) cs_n_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      res_v_q <= 1'b0;
    end else if (finish) begin
      res_q.ferr   <= |word[FRAME_BITS-1 -: LEAD_BITS];
      res_q.sample <= word[SUB_BITS +: DATA_BITS];
      res_q.sub    <= word[SUB_BITS-1:0];
      res_v_q      <= 1'b1;
    end else if (res_v_q && res_ready_i) begin
      res_v_q <= 1'b0;
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign spi_cs_n_o   = cs_n_q;
  assign spi_sclk_o   = sclk;
  assign res_valid_o  = res_v_q;
  assign res_sample_o = res_q.sample;
  assign res_sub_o    = res_q.sub;
  assign res_ferr_o   = res_q.ferr;

  // Cycles select has been high, saturating; used only by the checks below.
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt_q <= HW'(GUARD_EFF);
    else if (!cs_n_q)                   hi_cnt_q <= '0;
    else if (hi_cnt_q < HW'(GUARD_EFF)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R3: serial clock is low whenever select is high
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sclk_o);

  // R8: select falls only after the full guard interval
  p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> $past(hi_cnt_q) >= HW'(GUARD_EFF));

  // R7: a stalled result holds still
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_sample_o) &&
      $stable(res_sub_o) && $stable(res_ferr_o));

  // R7: no frame starts while a result waits
  p_no_start_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> !$past(res_valid_o));

  // R9: abort releases the link on the next edge
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && !spi_cs_n_o |=> spi_cs_n_o && !spi_sclk_o && !$rose(res_valid_o));

  // R4: a result only follows a frame whose select rise ends it
  p_result_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> $rose(spi_cs_n_o));

endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int DIV_HALF  = 21;
  localparam int CLK_PS    = 5000;
  localparam int GUARD_NS  = 50;
  localparam int GUARD_CYC = (GUARD_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, ready = 1'b1;
  logic miso = 1'b0;
  logic busy, cs, sclk, rvalid, ferr;
  logic [13:0] sample;
  logic [1:0]  sub;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.DIV_HALF(DIV_HALF), .CLK_PS(CLK_PS), .GUARD_NS(GUARD_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .busy_o(busy),
    .spi_cs_n_o(cs), .spi_sclk_o(sclk), .spi_miso_i(miso),
    .res_valid_o(rvalid), .res_ready_i(ready), .res_sample_o(sample),
    .res_sub_o(sub), .res_ferr_o(ferr)
  );

  int checks = 0, fails = 0;
  logic [16:0] exp_q[$];
  logic [23:0] dev_word = '0;
  bit exp_abort = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor, converter model and scoreboard, all sampled between edges.
  int cyc = 0, cs_fall_c = 0, cs_rise_c = -1, last_tog = 0, rises = 0, idx = 0;
  logic pcs = 1'b1, psclk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pcs && !cs) begin
        if (cs_rise_c >= 0)
          chk(cyc - cs_rise_c >= GUARD_CYC, "R8", "select high cycles", cyc - cs_rise_c, GUARD_CYC);
        cs_fall_c = cyc; rises = 0; idx = 0; miso = dev_word[23];
      end
      if (!psclk && sclk) begin
        rises++;
        if (rises == 1) chk(cyc - cs_fall_c == DIV_HALF, "R3", "first rise delay", cyc - cs_fall_c, DIV_HALF);
        else            chk(cyc - last_tog == DIV_HALF, "R3", "half period", cyc - last_tog, DIV_HALF);
        last_tog = cyc;
      end
      if (psclk && !sclk) begin
        if (!cs) chk(cyc - last_tog == DIV_HALF, "R3", "half period", cyc - last_tog, DIV_HALF);
        last_tog = cyc; idx++;
        miso = (idx < 24) ? dev_word[23-idx] : 1'b0;
      end
      if (!pcs && cs) begin
        if (exp_abort) begin
          chk(rises < 24, "R9", "rises before abort", rises, 24);
          exp_abort = 0;
        end else begin
          chk(rises == 24, "R4", "rising edges per frame", rises, 24);
          chk(psclk && !sclk, "R4", "select rise with 24th fall", {psclk, sclk}, 2'b10);
        end
        cs_rise_c = cyc;
      end
      if (cs && sclk) chk(0, "R3", "clock high with select high", 1, 0);
      if (rvalid && ready) begin
        if (exp_q.size() == 0) chk(0, "R9", "unexpected result", {ferr, sample, sub}, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({ferr, sample, sub} == e, "R5", "result fields", {ferr, sample, sub}, e);
          chk(ferr == e[16], "R6", "framing flag", ferr, e[16]);
        end
      end
    end
    pcs = cs; psclk = sclk;
  end

  task automatic load_dev(input logic [7:0] lead, input logic [13:0] s, input logic [1:0] sb);
    dev_word = {lead, s, sb};
    exp_q.push_back({|lead, s, sb});
  endtask

  task automatic do_frame(input logic [7:0] lead, input logic [13:0] s, input logic [1:0] sb);
    load_dev(lead, s, sb);
    start = 1'b1;
    while (cs) @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs == 1 && sclk == 0 && busy == 0 && rvalid == 0, "R1", "reset outputs",
        {cs, sclk, busy, rvalid}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs == 1 && busy == 0, "R1", "idle after reset", {cs, busy}, 2'b10);

    // R2: start is taken at the next edge
    load_dev(8'h00, 14'h2A5B, 2'b10);
    start = 1'b1;
    @(negedge clk);
    chk(cs == 0 && busy == 1, "R2", "select low after start", {cs, busy}, 2'b01);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);

    // R5 patterns, back to back so R8 guard is exercised with start held
    do_frame(8'h00, 14'h3FFF, 2'b11);
    do_frame(8'h00, 14'h0000, 2'b00);
    do_frame(8'h00, 14'h2001, 2'b01);
    // R6: a nonzero leading bit at either end of the lead group
    do_frame(8'h01, 14'h1234, 2'b10);
    do_frame(8'h80, 14'h0ABC, 2'b00);

    // R7: back-pressure holds the result and blocks a new start
    ready = 1'b0;
    load_dev(8'h00, 14'h155A, 2'b01);
    start = 1'b1;
    while (cs) @(negedge clk);
    start = 1'b0;
    while (!rvalid) @(negedge clk);
    start = 1'b1;
    repeat (40) @(negedge clk);
    chk(rvalid == 1, "R7", "valid held", rvalid, 1);
    chk(sample == 14'h155A && sub == 2'b01 && ferr == 0, "R7", "fields held",
        {ferr, sample, sub}, {1'b0, 14'h155A, 2'b01});
    chk(cs == 1, "R7", "no start while pending", cs, 1);
    load_dev(8'h00, 14'h0F0F, 2'b10);
    ready = 1'b1;
    while (cs) @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);

    // R9: abort mid-frame
    dev_word = {8'h00, 14'h3333, 2'b11};
    start = 1'b1;
    while (cs) @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    exp_abort = 1;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs == 1 && sclk == 0, "R9", "link released after abort", {cs, sclk}, 2'b10);
    repeat (60) @(negedge clk);
    chk(rvalid == 0, "R9", "no result after abort", rvalid, 0);
    do_frame(8'h00, 14'h1C3E, 2'b01);

    // R10: abort while idle does nothing
    repeat (20) @(negedge clk);
    abort = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs == 1 && busy == 0 && rvalid == 0, "R10", "idle abort ignored",
        {cs, busy, rvalid}, 3'b100);
    abort = 1'b0;
    do_frame(8'h00, 14'h0777, 2'b10);

    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule